// File: doc/BRIEF.md
# Condition Register Logic Unit

This block holds a 32-bit condition register made of eight 4-bit fields, together with the datapath that updates it. Each cycle in which `op_valid` is high, the unit applies one operation, and the register takes the result on the rising clock edge. The operation can be one of four kinds. A signed or unsigned compare writes a four-bit verdict into one chosen field. A two-input logic function combines two single bits and writes the result to a third. A field copy moves one whole field into another. A masked move takes selected nibbles from a general operand. The register is always visible on `cr_out`, so a general register can read the whole value unchanged.

Bits are numbered from the most significant end. Condition bit k sits at vector position 31-k. Field f covers positions 31-4f down to 28-4f, so field 0 is the top nibble. The masked move is the one exception: its mask bit i selects vector positions 4i+3..4i.

The design has no sequencing states. Its only state is the register itself. That register is held in one clocked process. A second, combinational process picks the next value from the decoded operation (IDLE when nothing is valid, otherwise COMPARE, BITLOGIC, COPY or MASKMOVE). Each cycle the register moves from its current value to that next value.

Top module: `cr_logic_unit`

## Requirements
- R1: When `rst_n` is low, the register is cleared, and `cr_out` reads 0x00000000 at the next check.
- R2: The register keeps its value in two cases: when `op_valid` is low, whatever the other inputs are; and when `op_code` is not one of 1 through 7.
- R3: Signed compares use `op_code` 1 (`opnd_a` against `opnd_b`) and 2 (`opnd_a` against `imm`, with `imm` sign-extended from 16 bits). The result goes into field `fld_dst`, at positions 31-4f..28-4f. The result is {LT,GT,EQ,SO}, with LT the most significant bit, and exactly one of LT, GT and EQ is set.
- R4: Unsigned compares use `op_code` 3 (`opnd_a` against `opnd_b`) and 4 (`opnd_a` against `imm`, with `imm` zero-extended). They use the same field layout and encoding as R3.
- R5: A compare puts `so_in` into the least significant bit of the field it writes, and leaves the other seven fields unchanged.
- R6: `op_code` 5 sets position 31-t to f(bit at 31-a, bit at 31-b), where a is `bit_a`, b is `bit_b` and t is `bit_t`. The function f is chosen by `func_code`: 257 AND, 449 OR, 255 NAND, 193 XOR, 33 NOR, 289 XNOR, 129 a AND NOT b, 417 a OR NOT b. No other bit changes. Any other `func_code` leaves the register unchanged.
- R7: `op_code` 6 copies field `fld_src` into field `fld_dst`. All other fields keep their value.
- R8: `op_code` 7 loads vector positions 4i+3..4i from `opnd_a` wherever `fld_mask[i]` is 1. Every other position keeps its old value.
- R9: The result of an operation appears on `cr_out` only after the rising edge that samples it. `cr_out` does not change combinationally with the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Apply the presented operation at this edge |
| op_code | input | 4 | Operation class (see R2 to R8) |
| func_code | input | 10 | Bit-logic function select for op 5 |
| bit_a | input | 5 | First source bit index |
| bit_b | input | 5 | Second source bit index |
| bit_t | input | 5 | Target bit index |
| fld_dst | input | 3 | Destination field index |
| fld_src | input | 3 | Source field index for copy |
| opnd_a | input | 32 | First operand / masked-move source |
| opnd_b | input | 32 | Second compare operand |
| imm | input | 16 | Compare immediate |
| fld_mask | input | 8 | Nibble mask for masked move |
| so_in | input | 1 | Summary-overflow bit for compares |
| cr_out | output | 32 | Current condition register |

## Verification
The assertions assume that every input is known (no X or Z) at each rising edge where `rst_n` is high. They also assume that `fld_dst` names the field a compare targets in the same cycle as `op_valid`. Because the bit indices span all 32 positions and the field indices span all eight fields, no index can fall out of range. The stimulus respects these assumptions. It changes inputs only on the falling edge and drives every port to a defined value from time zero, including while `op_valid` is low.

// File: rtl/cr_pkg.sv
package cr_pkg;

    typedef enum logic [3:0] {
        CR_NOP   = 4'd0,
        CR_CMPS  = 4'd1,
        CR_CMPSI = 4'd2,
        CR_CMPU  = 4'd3,
        CR_CMPUI = 4'd4,
        CR_BIT   = 4'd5,
        CR_COPY  = 4'd6,
        CR_MASK  = 4'd7
    } cr_op_e;

    localparam int FN_W = 10;

    localparam logic [FN_W-1:0] CR_FN_AND  = 10'd257;
    localparam logic [FN_W-1:0] CR_FN_OR   = 10'd449;
    localparam logic [FN_W-1:0] CR_FN_NAND = 10'd255;
    localparam logic [FN_W-1:0] CR_FN_XOR  = 10'd193;
    localparam logic [FN_W-1:0] CR_FN_NOR  = 10'd33;
    localparam logic [FN_W-1:0] CR_FN_XNOR = 10'd289;
    localparam logic [FN_W-1:0] CR_FN_ANDC = 10'd129;
    localparam logic [FN_W-1:0] CR_FN_ORC  = 10'd417;

endpackage

// File: rtl/cr_compare.sv
module cr_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         signed_mode,
    input  logic         so,
    output logic [3:0]   verdict
);
    logic lt;
    logic gt;
    logic eq;

    always_comb begin
        eq = (lhs == rhs);
        if (signed_mode) begin
            lt = ($signed(lhs) < $signed(rhs));
        end else begin
            lt = (lhs < rhs);
        end
        gt = !lt && !eq;
        verdict = {lt, gt, eq, so};
    end
endmodule

// File: rtl/cr_bitop.sv
module cr_bitop
    import cr_pkg::*;
#(
    parameter int W = 32,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]    cr,
    input  logic [FN_W-1:0] func,
    input  logic [IW-1:0]   ia,
    input  logic [IW-1:0]   ib,
    input  logic [IW-1:0]   it,
    output logic [W-1:0]    nxt
);
    logic ba;
    logic bb;
    logic res;
    logic known;

    always_comb begin
        ba    = cr[W-1-int'(ia)];
        bb    = cr[W-1-int'(ib)];
        known = 1'b1;
        case (func)
            CR_FN_AND:  res = ba & bb;
            CR_FN_OR:   res = ba | bb;
            CR_FN_NAND: res = ~(ba & bb);
            CR_FN_XOR:  res = ba ^ bb;
            CR_FN_NOR:  res = ~(ba | bb);
            CR_FN_XNOR: res = ~(ba ^ bb);
            CR_FN_ANDC: res = ba & ~bb;
            CR_FN_ORC:  res = ba | ~bb;
            default: begin
                res   = 1'b0;
                known = 1'b0;
            end
        endcase
        nxt = cr;
        if (known) begin
            nxt[W-1-int'(it)] = res;
        end
    end
endmodule

// File: rtl/cr_fieldmove.sv
module cr_fieldmove #(
    parameter int NF = 8,
    parameter int FW = 4,
    localparam int CRW = NF * FW,
    localparam int FLW = $clog2(NF)
) (
    input  logic [CRW-1:0] cr,
    input  logic [FLW-1:0] src,
    input  logic [FLW-1:0] dst,
    input  logic [NF-1:0]  mask,
    input  logic [CRW-1:0] gpr,
    output logic [CRW-1:0] copy_cr,
    output logic [CRW-1:0] mask_cr
);
    logic [FW-1:0] src_nib;

    assign src_nib = cr[FW*(NF-1-int'(src)) +: FW];

    for (genvar j = 0; j < NF; j++) begin : g_nib
        localparam int FIELD = NF - 1 - j;
        assign copy_cr[j*FW +: FW] = (dst == FLW'(FIELD)) ? src_nib : cr[j*FW +: FW];
        assign mask_cr[j*FW +: FW] = mask[j] ? gpr[j*FW +: FW] : cr[j*FW +: FW];
    end
endmodule

// File: rtl/cr_logic_unit.sv
module cr_logic_unit
    import cr_pkg::*;
#(
    parameter int NF = 8,
    parameter int FW = 4,
    parameter int IMW = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        op_valid,
    input  logic [3:0]                  op_code,
    input  logic [9:0]                  func_code,
    input  logic [$clog2(NF*FW)-1:0]    bit_a,
    input  logic [$clog2(NF*FW)-1:0]    bit_b,
    input  logic [$clog2(NF*FW)-1:0]    bit_t,
    input  logic [$clog2(NF)-1:0]       fld_dst,
    input  logic [$clog2(NF)-1:0]       fld_src,
    input  logic [NF*FW-1:0]            opnd_a,
    input  logic [NF*FW-1:0]            opnd_b,
    input  logic [IMW-1:0]              imm,
    input  logic [NF-1:0]               fld_mask,
    input  logic                        so_in,
    output logic [NF*FW-1:0]            cr_out
);
    localparam int CRW = NF * FW;

    cr_op_e          op;
    logic [CRW-1:0]  cr_q;
    logic [CRW-1:0]  cr_d;
    logic [CRW-1:0]  rhs;
    logic            cmp_signed;
    logic [3:0]      cmp_fld;
    logic [CRW-1:0]  cmp_cr;
    logic [CRW-1:0]  bit_cr;
    logic [CRW-1:0]  copy_cr;
    logic [CRW-1:0]  mask_cr;
    logic [CRW-1:0]  imm_sx;
    logic [CRW-1:0]  imm_zx;

    assign op     = cr_op_e'(op_code);
    assign imm_sx = {{(CRW-IMW){imm[IMW-1]}}, imm};
    assign imm_zx = {{(CRW-IMW){1'b0}}, imm};

    always_comb begin
        unique case (op)
            CR_CMPSI: rhs = imm_sx;
            CR_CMPUI: rhs = imm_zx;
            default:  rhs = opnd_b;
        endcase
        cmp_signed = (op == CR_CMPS) || (op == CR_CMPSI);
    end

    cr_compare #(.W(CRW)) u_cmp (
        .lhs         (opnd_a),
        .rhs         (rhs),
        .signed_mode (cmp_signed),
        .so          (so_in),
        .verdict     (cmp_fld)
    );

    always_comb begin
        cmp_cr = cr_q;
        cmp_cr[FW*(NF-1-int'(fld_dst)) +: FW] = cmp_fld;
    end

    cr_bitop #(.W(CRW)) u_bit (
        .cr   (cr_q),
        .func (func_code),
        .ia   (bit_a),
        .ib   (bit_b),
        .it   (bit_t),
        .nxt  (bit_cr)
    );

    cr_fieldmove #(.NF(NF), .FW(FW)) u_move (
        .cr      (cr_q),
        .src     (fld_src),
        .dst     (fld_dst),
        .mask    (fld_mask),
        .gpr     (opnd_a),
        .copy_cr (copy_cr),
        .mask_cr (mask_cr)
    );

    // next-value selection: IDLE, COMPARE, BITLOGIC, COPY, MASKMOVE
    always_comb begin
        cr_d = cr_q;
        if (op_valid) begin
            unique case (op)
                CR_CMPS, CR_CMPSI,
                CR_CMPU, CR_CMPUI: cr_d = cmp_cr;
                CR_BIT:            cr_d = bit_cr;
                CR_COPY:           cr_d = copy_cr;
                CR_MASK:           cr_d = mask_cr;
                default:           cr_d = cr_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cr_q <= '0;
        end else begin
            cr_q <= cr_d;
        end
    end

    assign cr_out = cr_q;
endmodule

// File: rtl/cr_logic_chk.sv
module cr_logic_chk
    import cr_pkg::*;
#(
    parameter int NF = 8,
    parameter int FW = 4,
    localparam int CRW = NF * FW,
    localparam int FLW = $clog2(NF)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           op_valid,
    input logic [3:0]     op_code,
    input logic [FLW-1:0] fld_dst,
    input logic [NF-1:0]  fld_mask,
    input logic           so_in,
    input logic [CRW-1:0] cr_out
);
    logic           vld_q;
    logic [3:0]     op_q;
    logic [FLW-1:0] dst_q;
    logic [NF-1:0]  mask_q;
    logic           so_q;
    logic [CRW-1:0] prev_q;
    logic [CRW-1:0] diff;
    logic [CRW-1:0] dst_bits;
    logic [CRW-1:0] sel_bits;
    logic [FW-1:0]  nib;
    logic           is_cmp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            op_q   <= '0;
            dst_q  <= '0;
            mask_q <= '0;
            so_q   <= 1'b0;
            prev_q <= '0;
        end else begin
            vld_q  <= op_valid;
            op_q   <= op_code;
            dst_q  <= fld_dst;
            mask_q <= fld_mask;
            so_q   <= so_in;
            prev_q <= cr_out;
        end
    end

    always_comb begin
        diff     = cr_out ^ prev_q;
        dst_bits = {{(CRW-FW){1'b0}}, {FW{1'b1}}} << (FW*(NF-1-int'(dst_q)));
        nib      = cr_out[FW*(NF-1-int'(dst_q)) +: FW];
        is_cmp   = vld_q && (op_q >= 4'd1) && (op_q <= 4'd4);
        for (int i = 0; i < NF; i++) begin
            sel_bits[i*FW +: FW] = {FW{mask_q[i]}};
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_q || op_q > 4'd7 || op_q == 4'd0) |-> (cr_out == prev_q));

    // R3 R4
    cmp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |-> ($countones(nib[FW-1:1]) == 1));

    // R5
    cmp_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |-> (nib[0] == so_q));

    // R5
    cmp_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |-> ((diff & ~dst_bits) == '0));

    // R6
    bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && op_q == 4'd5) |-> $onehot0(diff));

    // R7
    copy_only_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && op_q == 4'd6) |-> ((diff & ~dst_bits) == '0));

    // R8
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && op_q == 4'd7) |-> ((diff & ~sel_bits) == '0));
endmodule

bind cr_logic_unit cr_logic_chk #(.NF(NF), .FW(FW)) u_cr_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .fld_dst  (fld_dst),
    .fld_mask (fld_mask),
    .so_in    (so_in),
    .cr_out   (cr_out)
);

// File: tb/test_cr_logic_unit.sv
module test_cr_logic_unit;

    typedef struct packed {
        logic [3:0]  op;
        logic [9:0]  fn;
        logic [4:0]  ia;
        logic [4:0]  ib;
        logic [4:0]  it;
        logic [2:0]  fd;
        logic [2:0]  fs;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic [7:0]  mask;
        logic        so;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{4'd1, 10'd0,   5'd0,  5'd0,  5'd0,  3'd2, 3'd0, 32'd5,        32'd9,        16'h0000, 8'h00, 1'b1},
        '{4'd3, 10'd0,   5'd0,  5'd0,  5'd0,  3'd6, 3'd0, 32'hFFFF0000, 32'd1,        16'h0000, 8'h00, 1'b0},
        '{4'd2, 10'd0,   5'd0,  5'd0,  5'd0,  3'd1, 3'd0, 32'hFFFFFF00, 32'd0,        16'hFF00, 8'h00, 1'b0},
        '{4'd4, 10'd0,   5'd0,  5'd0,  5'd0,  3'd4, 3'd0, 32'h00000010, 32'd0,        16'h8000, 8'h00, 1'b1},
        '{4'd7, 10'd0,   5'd0,  5'd0,  5'd0,  3'd0, 3'd0, 32'hDEADBEEF, 32'd0,        16'h0000, 8'hA5, 1'b0},
        '{4'd5, 10'd449, 5'd0,  5'd5,  5'd12, 3'd0, 3'd0, 32'd0,        32'd0,        16'h0000, 8'h00, 1'b0},
        '{4'd5, 10'd255, 5'd2,  5'd2,  5'd30, 3'd0, 3'd0, 32'd0,        32'd0,        16'h0000, 8'h00, 1'b0},
        '{4'd5, 10'd193, 5'd1,  5'd3,  5'd7,  3'd0, 3'd0, 32'd0,        32'd0,        16'h0000, 8'h00, 1'b0},
        '{4'd5, 10'd33,  5'd8,  5'd9,  5'd16, 3'd0, 3'd0, 32'd0,        32'd0,        16'h0000, 8'h00, 1'b0},
        '{4'd5, 10'd289, 5'd4,  5'd31, 5'd4,  3'd0, 3'd0, 32'd0,        32'd0,        16'h0000, 8'h00, 1'b0},
        '{4'd5, 10'd129, 5'd24, 5'd25, 5'd1,  3'd0, 3'd0, 32'd0,        32'd0,        16'h0000, 8'h00, 1'b0},
        '{4'd5, 10'd417, 5'd6,  5'd20, 5'd26, 3'd0, 3'd0, 32'd0,        32'd0,        16'h0000, 8'h00, 1'b0},
        '{4'd5, 10'd257, 5'd0,  5'd1,  5'd2,  3'd0, 3'd0, 32'd0,        32'd0,        16'h0000, 8'h00, 1'b0},
        '{4'd6, 10'd0,   5'd0,  5'd0,  5'd0,  3'd0, 3'd4, 32'd0,        32'd0,        16'h0000, 8'h00, 1'b0},
        '{4'd0, 10'd257, 5'd1,  5'd2,  5'd3,  3'd3, 3'd1, 32'h12345678, 32'h1,        16'h0001, 8'hFF, 1'b1},
        '{4'd9, 10'd257, 5'd1,  5'd2,  5'd3,  3'd3, 3'd1, 32'h12345678, 32'h1,        16'h0001, 8'hFF, 1'b1}
    };

    logic        clk;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [9:0]  func_code;
    logic [4:0]  bit_a;
    logic [4:0]  bit_b;
    logic [4:0]  bit_t;
    logic [2:0]  fld_dst;
    logic [2:0]  fld_src;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [15:0] imm;
    logic [7:0]  fld_mask;
    logic        so_in;
    logic [31:0] cr_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    cr_logic_unit i_cr_logic_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .func_code (func_code),
        .bit_a     (bit_a),
        .bit_b     (bit_b),
        .bit_t     (bit_t),
        .fld_dst   (fld_dst),
        .fld_src   (fld_src),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .imm       (imm),
        .fld_mask  (fld_mask),
        .so_in     (so_in),
        .cr_out    (cr_out)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd1, 4'd2: return "R3";
            4'd3, 4'd4: return "R4";
            4'd5:       return "R6";
            4'd6:       return "R7";
            4'd7:       return "R8";
            default:    return "R2";
        endcase
    endfunction

    // independent reference drawn from the requirements
    function automatic logic [31:0] model(input logic [31:0] cr, input vec_t v);
        logic [31:0] r;
        logic [31:0] rhs;
        logic        lt;
        logic        eq;
        logic        x;
        logic        y;
        logic        z;
        r = cr;
        case (v.op)
            4'd1, 4'd2, 4'd3, 4'd4: begin
                rhs = v.b;
                if (v.op == 4'd2) rhs = {{16{v.imm[15]}}, v.imm};
                if (v.op == 4'd4) rhs = {16'h0000, v.imm};
                eq = (v.a == rhs);
                lt = (v.op <= 4'd2) ? ($signed(v.a) < $signed(rhs)) : (v.a < rhs);
                r[31-4*v.fd -: 4] = {lt, !lt && !eq, eq, v.so};
            end
            4'd5: begin
                x = cr[31-v.ia];
                y = cr[31-v.ib];
                case (v.fn)
                    10'd257: z = x & y;
                    10'd449: z = x | y;
                    10'd255: z = !(x & y);
                    10'd193: z = x ^ y;
                    10'd33:  z = !(x | y);
                    10'd289: z = (x == y);
                    10'd129: z = x & !y;
                    10'd417: z = x | !y;
                    default: z = cr[31-v.it];
                endcase
                r[31-v.it] = z;
            end
            4'd6: r[31-4*v.fd -: 4] = cr[31-4*v.fs -: 4];
            4'd7: begin
                for (int i = 0; i < 8; i++) begin
                    if (v.mask[i]) r[4*i +: 4] = v.a[4*i +: 4];
                end
            end
            default: r = cr;
        endcase
        return r;
    endfunction

    task automatic put(input vec_t v, input logic vld);
        op_valid  = vld;
        op_code   = v.op;
        func_code = v.fn;
        bit_a     = v.ia;
        bit_b     = v.ib;
        bit_t     = v.it;
        fld_dst   = v.fd;
        fld_src   = v.fs;
        opnd_a    = v.a;
        opnd_b    = v.b;
        imm       = v.imm;
        fld_mask  = v.mask;
        so_in     = v.so;
    endtask

    task automatic step(input vec_t v, input logic vld);
        put(v, vld);
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    function automatic vec_t mk(input logic [3:0] op, input logic [9:0] fn,
                                input logic [4:0] ia, input logic [4:0] ib, input logic [4:0] it,
                                input logic [2:0] fd, input logic [2:0] fs,
                                input logic [31:0] a, input logic [31:0] b,
                                input logic [15:0] im, input logic [7:0] m, input logic so);
        vec_t v;
        v = '{op, fn, ia, ib, it, fd, fs, a, b, im, m, so};
        return v;
    endfunction

    initial begin
        logic [31:0] exp_cr;
        rst_n = 1'b0;
        put('0, 1'b0);
        repeat (3) @(negedge clk);
        check("R1 reset value", cr_out, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        exp_cr = 32'h0;
        for (int n = 0; n < NV; n++) begin
            exp_cr = model(exp_cr, VEC[n]);
            step(VEC[n], 1'b1);
            check(tag_of(VEC[n].op), cr_out, exp_cr);
        end

        // R1: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", cr_out, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 with R9: result only after the edge
        put(mk(4'd1, 10'd0, 5'd0, 5'd0, 5'd0, 3'd0, 3'd0, 32'h80000000, 32'd1, 16'h0, 8'h0, 1'b0), 1'b1);
        #1;
        check("R9 no change before edge", cr_out, 32'h0);
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        check("R3 signed min vs one", cr_out, 32'h80000000);

        step(mk(4'd3, 10'd0, 5'd0, 5'd0, 5'd0, 3'd7, 3'd0, 32'h80000000, 32'd1, 16'h0, 8'h0, 1'b0), 1'b1);
        check("R4 unsigned reg field 7", cr_out, 32'h80000004);

        step(mk(4'd2, 10'd0, 5'd0, 5'd0, 5'd0, 3'd3, 3'd0, 32'hFFFFFFFF, 32'd0, 16'hFFFF, 8'h0, 1'b1), 1'b1);
        check("R5 signed imm equal with SO", cr_out, 32'h80030004);

        step(mk(4'd4, 10'd0, 5'd0, 5'd0, 5'd0, 3'd3, 3'd0, 32'hFFFFFFFF, 32'd0, 16'hFFFF, 8'h0, 1'b0), 1'b1);
        check("R4 unsigned imm zero-extended", cr_out, 32'h80040004);

        step(mk(4'd7, 10'd0, 5'd0, 5'd0, 5'd0, 3'd0, 3'd0, 32'hFFFFFFFF, 32'd0, 16'h0, 8'hFF, 1'b1), 1'b0);
        check("R2 valid low ignored", cr_out, 32'h80040004);

        step(mk(4'd7, 10'd0, 5'd0, 5'd0, 5'd0, 3'd0, 3'd0, 32'h12345678, 32'd0, 16'h0, 8'h81, 1'b0), 1'b1);
        check("R8 masked nibbles 7 and 0", cr_out, 32'h10040008);

        step(mk(4'd6, 10'd0, 5'd0, 5'd0, 5'd0, 3'd5, 3'd0, 32'd0, 32'd0, 16'h0, 8'h0, 1'b0), 1'b1);
        check("R7 copy field 0 to 5", cr_out, 32'h10040108);

        step(mk(4'd5, 10'd257, 5'd3, 5'd23, 5'd31, 3'd0, 3'd0, 32'd0, 32'd0, 16'h0, 8'h0, 1'b0), 1'b1);
        check("R6 AND into bit 31", cr_out, 32'h10040109);

        step(mk(4'd5, 10'h3FF, 5'd3, 5'd23, 5'd0, 3'd0, 3'd0, 32'd0, 32'd0, 16'h0, 8'h0, 1'b0), 1'b1);
        check("R6 unknown function code", cr_out, 32'h10040109);

        step(mk(4'hF, 10'd257, 5'd3, 5'd23, 5'd0, 3'd2, 3'd0, 32'hFFFFFFFF, 32'd0, 16'h0, 8'hFF, 1'b1), 1'b1);
        check("R2 undefined op code", cr_out, 32'h10040109);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule